// File: doc/BRIEF.md
# CPU Bus Cycle Front End with PC Memory Decode

This block sits between a CPU with a 16-bit data bus and a 24-bit address bus and the memories that answer it. When the CPU pulls its address strobe low, the block captures the address, the write data, the two active-low byte enables and the cycle type. The cycle type is write/read (1 = write) and memory/IO (1 = memory). The block then walks a three-state machine, IDLE -> T1 -> T2, and acknowledges the transfer with an active-low ready. The request for the next address is held inactive, so the CPU never pipelines.

The captured address is decoded against a PC-style map. External SRAM answers below 640 KB (0x000000-0x09FFFF). The whole of it also appears again in the 1 MB window 0x100000-0x1FFFFF. A 32 KB internal boot memory answers at 0xFF8000-0xFFFFFF and, through an alias, at 0x0F8000-0x0FFFFF. The boot memory is outside this block and is reached through a synchronous port with one cycle of read latency. The block steers its read data onto the byte lanes the CPU asked for. A debug unit can take the bus over at any time through an override input.

State transitions: IDLE -> T1 when the strobe is sampled low; T1 -> T2 when the strobe is high; T1 -> T1 or T2 -> T1 when the strobe is low again; T2 -> IDLE when the strobe is high.

Top module: `cpu_bus_front`

## Requirements
- R1: A rising edge that samples `ads_n` low captures address, write data, byte enables, write/read and memory/IO. It sets `rdy_n` high and enters T1, whatever the current state.
- R2: A rising edge in T1 that samples `ads_n` high drives `rdy_n` low and enters T2. `rdy_n` then stays low until the next sampled strobe, and T2 with the strobe high returns to IDLE.
- R3: Lane enable `data_oe_hi` (upper byte, bits 15:8) is high only in T1 or T2 of a memory read that hits the boot memory with `be_hi_n` low. `data_oe_lo` (bits 7:0) follows the same rule with `be_lo_n`. Both are low in every other case.
- R4: `sram_cs_n` is low in T1 and T2 of a memory cycle whose captured address is below 0x0A0000 or has bits 23:20 equal to 1. It is high otherwise.
- R5: The boot memory is hit when address bits 23:15 equal 0x1FF or 0x01F. `bmem_en` pulses for exactly the T1 cycle with `bmem_addr` = address bits 14:1. The word read appears on `data_out` during T2.
- R6: `sram_we_n` is the inverse of the captured write/read bit: low for writes, high for reads.
- R7: A boot-memory write asserts `bmem_we` together with `bmem_en`. `bmem_be` bit 1 is the inverse of `be_hi_n` and bit 0 is the inverse of `be_lo_n`, so only the requested bytes change.
- R8: An IO cycle (memory/IO = 0) asserts no chip select, yet `rdy_n` still falls in T2.
- R9: While `dbg_en` is high, `rdy_oe`, `data_oe_hi` and `data_oe_lo` are all low.
- R10: `na_n` is high at all times.
- R11: In reset, `rdy_n` is high, `sram_cs_n` is high, `bmem_en` is low and the state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe from the CPU, active low |
| addr | input | 23 | CPU address bits 23:1 |
| data_in | input | 16 | Data bus as seen from the CPU side |
| be_hi_n | input | 1 | Upper byte enable, active low |
| be_lo_n | input | 1 | Lower byte enable, active low |
| wr | input | 1 | Cycle direction, 1 = write |
| mio | input | 1 | Cycle space, 1 = memory, 0 = IO |
| dbg_en | input | 1 | Debug unit owns ready and data bus |
| rdy_n | output | 1 | Transfer acknowledge, active low |
| rdy_oe | output | 1 | Drive enable for rdy_n |
| na_n | output | 1 | Next-address request, held inactive |
| data_out | output | 16 | Read data toward the CPU |
| data_oe_hi | output | 1 | Drive enable for data_out bits 15:8 |
| data_oe_lo | output | 1 | Drive enable for data_out bits 7:0 |
| sram_cs_n | output | 1 | External SRAM chip select, active low |
| sram_we_n | output | 1 | External SRAM write enable, active low |
| bmem_en | output | 1 | Boot memory access strobe |
| bmem_we | output | 1 | Boot memory write |
| bmem_be | output | 2 | Boot memory byte write mask |
| bmem_addr | output | 14 | Boot memory word address |
| bmem_wdata | output | 16 | Boot memory write data |
| bmem_rdata | input | 16 | Boot memory read data, one cycle after bmem_en |

## Verification
The bench probes the edges of every window:
- 0x09FFFE against 0x0A0000,
- 0x1FFFFE against 0x200000,
- 0x0F7FFE and 0xFF7FFE against the first boot words,
- 0x0FFFFE at the very top of the alias.

An off-by-one decode would leak a chip select into the gap or lose the last word.

An upper-byte-only write followed by reads through both aliases, with single lanes enabled, exposes swapped byte masks or swapped lane enables as wrong bytes on the bus. An IO cycle placed at a boot address would show whether the decoder ignores the memory/IO bit. A held strobe covering two back-to-back cycles, and a read under debug override, show whether ready falls too early and whether the block still drives the bus while the debug unit owns it.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic wr;
        logic mio;
        logic hi_n;
        logic lo_n;
    } cyc_ctl_t;

endpackage

// File: rtl/cbf_fsm.sv
module cbf_fsm
    import cbf_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic [ADDR_W-1:1] addr,
    input  logic [DATA_W-1:0] data_in,
    input  cyc_ctl_t          ctl_in,
    output bus_state_e        state,
    output logic [ADDR_W-1:1] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output cyc_ctl_t          cap_ctl,
    output logic              rdy_n
);

    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!ads_n) state_d = ST_T1;
            ST_T1:   state_d = ads_n ? ST_T2 : ST_T1;
            ST_T2:   state_d = ads_n ? ST_IDLE : ST_T1;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_n    <= 1'b1;
            cap_addr <= '0;
            cap_data <= '0;
            cap_ctl  <= '{wr: 1'b0, mio: 1'b0, hi_n: 1'b1, lo_n: 1'b1};
        end else if (!ads_n) begin
            rdy_n    <= 1'b1;
            cap_addr <= addr;
            cap_data <= data_in;
            cap_ctl  <= ctl_in;
        end else if (state_q == ST_T1) begin
            rdy_n <= 1'b0;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/cbf_decode.sv
module cbf_decode #(
    parameter int ADDR_W  = 24,
    parameter int BOOT_AW = 14,
    parameter logic [7:0] LOW_TOP   = 8'h0A,
    parameter logic [3:0] ALIAS_NIB = 4'h1,
    parameter logic [ADDR_W-BOOT_AW-2:0] BOOT_HI = 9'h1FF,
    parameter logic [ADDR_W-BOOT_AW-2:0] BOOT_LO = 9'h01F
) (
    input  logic [ADDR_W-1:1] addr,
    input  logic              mio,
    output logic              sram_hit,
    output logic              boot_hit
);

    localparam int TAG_LSB = BOOT_AW + 1;

    logic [7:0]                  top_byte;
    logic [3:0]                  top_nib;
    logic [ADDR_W-TAG_LSB-1:0]   boot_tag;

    assign top_byte = addr[ADDR_W-1 -: 8];
    assign top_nib  = addr[ADDR_W-1 -: 4];
    assign boot_tag = addr[ADDR_W-1:TAG_LSB];

    assign sram_hit = mio && ((top_byte < LOW_TOP) || (top_nib == ALIAS_NIB));
    assign boot_hit = mio && ((boot_tag == BOOT_HI) || (boot_tag == BOOT_LO));

endmodule

// File: rtl/cbf_lanes.sv
module cbf_lanes #(
    parameter int LANES = 2
) (
    input  logic             dbg_en,
    input  logic             active,
    input  logic             wr,
    input  logic             boot_hit,
    input  logic [LANES-1:0] be_n,
    output logic [LANES-1:0] lane_oe
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_oe[g] = !dbg_en && active && !wr && boot_hit && !be_n[g];
    end

endmodule

// File: rtl/cpu_bus_front.sv
module cpu_bus_front
    import cbf_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int BOOT_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic [ADDR_W-1:1] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              be_hi_n,
    input  logic              be_lo_n,
    input  logic              wr,
    input  logic              mio,
    input  logic              dbg_en,
    output logic              rdy_n,
    output logic              rdy_oe,
    output logic              na_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe_hi,
    output logic              data_oe_lo,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              bmem_en,
    output logic              bmem_we,
    output logic [1:0]        bmem_be,
    output logic [BOOT_AW-1:0] bmem_addr,
    output logic [DATA_W-1:0] bmem_wdata,
    input  logic [DATA_W-1:0] bmem_rdata
);

    localparam int LANES = DATA_W / 8;

    bus_state_e        state;
    logic [ADDR_W-1:1] cap_addr;
    logic [DATA_W-1:0] cap_data;
    cyc_ctl_t          cap_ctl;
    cyc_ctl_t          ctl_in;
    logic              sram_hit, boot_hit, active;
    logic [LANES-1:0]  lane_oe;

    assign ctl_in = '{wr: wr, mio: mio, hi_n: be_hi_n, lo_n: be_lo_n};

    cbf_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ads_n    (ads_n),
        .addr     (addr),
        .data_in  (data_in),
        .ctl_in   (ctl_in),
        .state    (state),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .cap_ctl  (cap_ctl),
        .rdy_n    (rdy_n)
    );

    cbf_decode #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW)) i_dec (
        .addr     (cap_addr),
        .mio      (cap_ctl.mio),
        .sram_hit (sram_hit),
        .boot_hit (boot_hit)
    );

    cbf_lanes #(.LANES(LANES)) i_lanes (
        .dbg_en   (dbg_en),
        .active   (active),
        .wr       (cap_ctl.wr),
        .boot_hit (boot_hit),
        .be_n     ({cap_ctl.hi_n, cap_ctl.lo_n}),
        .lane_oe  (lane_oe)
    );

    // Output process: everything here follows the state register.
    always_comb begin
        active     = 1'b0;
        bmem_en    = 1'b0;
        unique case (state)
            ST_IDLE: active = 1'b0;
            ST_T1: begin
                active  = 1'b1;
                bmem_en = boot_hit;
            end
            ST_T2:   active = 1'b1;
            default: active = 1'b0;
        endcase
        bmem_we    = bmem_en && cap_ctl.wr;
        sram_cs_n  = !(active && sram_hit);
        sram_we_n  = !cap_ctl.wr;
        rdy_oe     = !dbg_en;
        na_n       = 1'b1;
        data_oe_hi = lane_oe[1];
        data_oe_lo = lane_oe[0];
    end

    assign bmem_be    = {!cap_ctl.hi_n, !cap_ctl.lo_n};
    assign bmem_addr  = cap_addr[BOOT_AW:1];
    assign bmem_wdata = cap_data;
    assign data_out   = bmem_rdata;

endmodule

// File: rtl/cbf_checker.sv
module cbf_checker (
    input logic clk,
    input logic rst_n,
    input logic ads_n,
    input logic dbg_en,
    input logic rdy_n,
    input logic rdy_oe,
    input logic data_oe_hi,
    input logic data_oe_lo,
    input logic sram_cs_n,
    input logic sram_we_n,
    input logic bmem_en,
    input logic bmem_we
);

    AST_STROBE_RAISES_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> rdy_n);                                                   // R1
    AST_T1_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n ##1 ads_n) |=> !rdy_n);                                      // R2
    AST_LANES_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_hi || data_oe_lo) |-> sram_we_n);                           // R3
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bmem_en && !sram_cs_n));                                           // R4
    AST_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bmem_we |-> (bmem_en && !sram_we_n));                                // R7
    AST_DBG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_en |-> (!rdy_oe && !data_oe_hi && !data_oe_lo));                 // R9

endmodule

bind cpu_bus_front cbf_checker i_cbf_checker (.*);

// File: tb/test_cpu_bus_front.sv
module test_cpu_bus_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads_n = 1'b1;
    logic [23:1] addr = '0;
    logic [15:0] data_in = '0;
    logic        be_hi_n = 1'b1, be_lo_n = 1'b1, wr = 1'b0, mio = 1'b1, dbg_en = 1'b0;
    logic        rdy_n, rdy_oe, na_n, data_oe_hi, data_oe_lo;
    logic [15:0] data_out, bmem_wdata;
    logic [15:0] bmem_rdata = 16'h0000;
    logic        sram_cs_n, sram_we_n, bmem_en, bmem_we;
    logic [1:0]  bmem_be;
    logic [13:0] bmem_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cpu_bus_front i_cpu_bus_front (.*);

    // Boot memory model: synchronous, one cycle read latency
    logic [15:0] mem [int];
    always @(posedge clk) begin
        if (bmem_en) begin
            logic [15:0] w;
            w = mem.exists(int'(bmem_addr)) ? mem[int'(bmem_addr)] : 16'hDEAD;
            bmem_rdata <= w;
            if (bmem_we) begin
                if (bmem_be[1]) w[15:8] = bmem_wdata[15:8];
                if (bmem_be[0]) w[7:0]  = bmem_wdata[7:0];
                mem[int'(bmem_addr)] = w;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit in_sram(input logic [23:0] a);
        return (a < 24'h0A0000) || (a >= 24'h100000 && a < 24'h200000);
    endfunction

    function automatic bit in_boot(input logic [23:0] a);
        return (a >= 24'h0F8000 && a < 24'h100000) || (a >= 24'hFF8000);
    endfunction

    // Reference model: phase 0 idle, 1 first cycle after strobe, 2 acknowledge
    int          ph = 0;
    bit          erdy = 1'b1;
    logic [23:0] ca = '0;
    bit          cwr = 0, cmio = 0, chn = 1, cln = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; erdy = 1; cwr = 0; cmio = 0; chn = 1; cln = 1; ca = '0;
        end else if (!ads_n) begin
            ph = 1; erdy = 1;
            ca = {addr, 1'b0}; cwr = wr; cmio = mio; chn = be_hi_n; cln = be_lo_n;
        end else if (ph == 1) begin
            ph = 2; erdy = 0;
        end else if (ph == 2) begin
            ph = 0;
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit act, ben, ohi, olo;
            act = (ph != 0);
            ben = (ph == 1) && cmio && in_boot(ca);
            ohi = !dbg_en && act && !cwr && cmio && in_boot(ca) && !chn;
            olo = !dbg_en && act && !cwr && cmio && in_boot(ca) && !cln;
            chk(rdy_n === erdy, (ph == 2) ? "R2" : "R1", rdy_n, erdy);
            chk(sram_cs_n === !(act && cmio && in_sram(ca)), "R4", sram_cs_n, !(act && cmio && in_sram(ca)));
            chk(bmem_en === ben, "R5", bmem_en, ben);
            if (ben) chk(bmem_addr === ca[14:1], "R5", bmem_addr, ca[14:1]);
            chk(bmem_we === (ben && cwr), "R7", bmem_we, ben && cwr);
            if (ben) chk(bmem_be === {!chn, !cln}, "R7", bmem_be, {!chn, !cln});
            chk(sram_we_n === !cwr, "R6", sram_we_n, !cwr);
            chk(data_oe_hi === ohi, "R3", data_oe_hi, ohi);
            chk(data_oe_lo === olo, "R3", data_oe_lo, olo);
            chk(rdy_oe === !dbg_en, "R9", rdy_oe, !dbg_en);
            chk(na_n === 1'b1, "R10", na_n, 1'b1);
        end
    end

    task automatic cyc(input logic [23:0] a, input bit w, input bit m, input bit hn, input bit ln,
                       input logic [15:0] wd, input bit rd_chk, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a[23:1]; wr = w; mio = m; be_hi_n = hn; be_lo_n = ln; data_in = wd; ads_n = 1'b0;
        @(negedge clk);
        ads_n = 1'b1;
        @(negedge clk);
        #1;
        if (rd_chk) begin
            if (!hn) chk(data_oe_hi && data_out[15:8] === exp[15:8], tag, {data_oe_hi, data_out[15:8]}, {1'b1, exp[15:8]});
            if (!ln) chk(data_oe_lo && data_out[7:0] === exp[7:0], tag, {data_oe_lo, data_out[7:0]}, {1'b1, exp[7:0]});
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(rdy_n === 1'b1, "R11", rdy_n, 1);
        chk(sram_cs_n === 1'b1, "R11", sram_cs_n, 1);
        chk(bmem_en === 1'b0, "R11", bmem_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // boot memory writes and reads through both aliases
        cyc(24'hFF8010, 1, 1, 0, 0, 16'hA5C3, 0, 16'h0, "R7");
        cyc(24'h0F8010, 0, 1, 0, 0, 16'h0000, 1, 16'hA5C3, "R5");
        cyc(24'hFF8010, 1, 1, 0, 1, 16'h7E11, 0, 16'h0, "R7");
        cyc(24'hFF8010, 0, 1, 0, 0, 16'h0000, 1, 16'h7EC3, "R7");
        cyc(24'h0F8010, 0, 1, 1, 0, 16'h0000, 1, 16'h7EC3, "R3");
        cyc(24'h0F8010, 0, 1, 0, 1, 16'h0000, 1, 16'h7EC3, "R3");
        cyc(24'hFFFFFE, 1, 1, 0, 0, 16'h1234, 0, 16'h0, "R7");
        cyc(24'h0FFFFE, 0, 1, 0, 0, 16'h0000, 1, 16'h1234, "R5");

        // window edges (checked by the reference model every clock)
        cyc(24'h000100, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R4");
        cyc(24'h09FFFE, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R4");
        cyc(24'h0A0000, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R4");
        cyc(24'h100000, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R4");
        cyc(24'h1FFFFE, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R4");
        cyc(24'h200000, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R4");
        cyc(24'h0F7FFE, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R5");
        cyc(24'hFF7FFE, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R5");
        cyc(24'h000200, 1, 1, 0, 0, 16'hBEEF, 0, 16'h0, "R6");

        // IO cycle at a boot address: nothing selected, ready still returned
        @(negedge clk);
        addr = 24'hFF8010 >> 1; wr = 0; mio = 0; be_hi_n = 0; be_lo_n = 0; ads_n = 0;
        @(negedge clk);
        ads_n = 1;
        #1;
        chk(sram_cs_n === 1'b1 && bmem_en === 1'b0, "R8", {sram_cs_n, bmem_en}, 2'b10);
        @(negedge clk);
        #1;
        chk(rdy_n === 1'b0, "R8", rdy_n, 0);
        chk(data_oe_hi === 1'b0 && data_oe_lo === 1'b0, "R8", {data_oe_hi, data_oe_lo}, 0);

        // debug override during a boot read
        @(negedge clk);
        dbg_en = 1'b1;
        cyc(24'hFF8010, 0, 1, 0, 0, 16'h0, 0, 16'h0, "R9");
        #1;
        chk(rdy_oe === 1'b0 && data_oe_hi === 1'b0, "R9", {rdy_oe, data_oe_hi}, 0);
        @(negedge clk);
        dbg_en = 1'b0;

        // strobe held low over two consecutive edges
        @(negedge clk);
        addr = 24'h000400 >> 1; wr = 0; mio = 1; be_hi_n = 0; be_lo_n = 0; ads_n = 0;
        @(negedge clk);
        addr = 24'hFF8010 >> 1;
        #1;
        chk(rdy_n === 1'b1, "R1", rdy_n, 1);
        @(negedge clk);
        ads_n = 1;
        #1;
        chk(rdy_n === 1'b1, "R1", rdy_n, 1);
        @(negedge clk);
        #1;
        chk(rdy_n === 1'b0, "R2", rdy_n, 0);
        chk(data_out === 16'h7EC3, "R5", data_out, 16'h7EC3);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule